// File: doc/BRIEF.md
# Four-Phase Clock-Domain Word Transfer

This block carries single data words from a sending clock domain into an unrelated receiving clock domain. It needs no buffer memory. The sender offers a word with a valid/ready pair. Once the word is accepted, the block holds it in a register and raises a request flag. The receiver sees that flag through two synchronising flops, copies the word, announces it with a one-cycle strobe and raises an acknowledge flag. The acknowledge travels back through two more synchronising flops. The sender then lowers its request, and the receiver lowers the acknowledge once it sees the request gone.

Only after this full return to zero does the sender take a new word. Every transfer therefore costs several cycles in each domain. In exchange the design is simple and safe across any ratio between the two clocks. Each domain has its own active-high asynchronous reset.

Top module: `xclk_handshake`

## Requirements
- R1: While either reset is high and right after release, `send_ready` is 1 and `rx_valid` is 0.
- R2: On a sending-clock edge where `send_valid` and `send_ready` are both 1, the word on `send_data` is accepted and `send_ready` is 0 from the next cycle.
- R3: The accepted word stays unchanged in the sending domain for as long as the request flag is high, and `rx_data` shows exactly that word.
- R4: Every accepted word produces exactly one `rx_valid` pulse, one receiving-clock cycle long, and words come out in the order they were accepted. No word is lost and none is repeated.
- R5: `send_ready` comes back only after the acknowledge has been seen high and then low in the sending domain. After an accept it stays low for at least 3 sending-clock cycles, and it never rises before the receiver has strobed the word.
- R6: While `send_ready` is 0, values on `send_valid` and `send_data` have no effect. No extra word is delivered and the word in flight is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Sending-domain clock |
| src_rst | input | 1 | Sending-domain asynchronous reset, active high |
| send_valid | input | 1 | Sender offers a word |
| send_ready | output | 1 | Block can take a word |
| send_data | input | W | Word offered by the sender |
| dst_clk | input | 1 | Receiving-domain clock |
| dst_rst | input | 1 | Receiving-domain asynchronous reset, active high |
| rx_valid | output | 1 | One-cycle strobe marking a delivered word |
| rx_data | output | W | Delivered word, valid while `rx_valid` is 1 |

## Verification
The assertions assume that each reset is held across at least one edge of its own clock before the handshake starts. They also assume that both resets are released into an idle handshake, not in the middle of a transfer.

The stimulus asserts both resets together from time zero and releases them once, with no word in flight. It then never resets again. Within that envelope the sender is free to toggle `send_valid` and `send_data` on any cycle, including while busy. This is how the ignore rule is exercised. The receiving clock is switched between faster and slower than the sending clock.

// File: rtl/xclk_handshake.sv
module xclk_handshake #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         send_valid,
  output logic         send_ready,
  input  logic [W-1:0] send_data,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);

  logic         req_q;
  logic [W-1:0] hold_q;
  logic         ack_m, ack_s;
  logic         req_m, req_s;
  logic         ack_q;

  assign send_ready = !req_q && !ack_s;

  always_ff @(posedge src_clk or posedge src_rst)
    if (src_rst) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ack_q;
      ack_s <= ack_m;
    end

  always_ff @(posedge src_clk or posedge src_rst)
    if (src_rst) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (send_valid && send_ready) begin
      req_q  <= 1'b1;
      hold_q <= send_data;
    end else if (req_q && ack_s) begin
      req_q  <= 1'b0;
    end

  always_ff @(posedge dst_clk or posedge dst_rst)
    if (dst_rst) begin
      req_m <= 1'b0;
      req_s <= 1'b0;
    end else begin
      req_m <= req_q;
      req_s <= req_m;
    end

  always_ff @(posedge dst_clk or posedge dst_rst)
    if (dst_rst) begin
      ack_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (req_s && !ack_q) begin
        ack_q    <= 1'b1;
        rx_valid <= 1'b1;
        rx_data  <= hold_q;
      end else if (!req_s && ack_q) begin
        ack_q    <= 1'b0;
      end
    end

endmodule

// File: rtl/xclk_handshake_chk.sv
module xclk_handshake_chk #(
  parameter int W = 8
) (
  input logic         src_clk,
  input logic         src_rst,
  input logic         dst_clk,
  input logic         dst_rst,
  input logic         send_valid,
  input logic         send_ready,
  input logic         req_q,
  input logic         ack_s,
  input logic [W-1:0] hold_q,
  input logic         req_s,
  input logic         ack_q,
  input logic         rx_valid
);

  a_r2_accept_closes: assert property (@(posedge src_clk) disable iff (src_rst)
    send_valid && send_ready |=> req_q && !send_ready);

  a_r3_word_held: assert property (@(posedge src_clk) disable iff (src_rst)
    req_q |=> !req_q || $stable(hold_q));

  a_r5_req_waits_ack: assert property (@(posedge src_clk) disable iff (src_rst)
    req_q && !ack_s |=> req_q);

  a_r4_single_strobe: assert property (@(posedge dst_clk) disable iff (dst_rst)
    rx_valid |=> !rx_valid);

  a_r4_strobe_with_ack: assert property (@(posedge dst_clk) disable iff (dst_rst)
    rx_valid |-> ack_q && req_s);

  a_r5_ack_waits_req: assert property (@(posedge dst_clk) disable iff (dst_rst)
    ack_q && req_s |=> ack_q);

endmodule

bind xclk_handshake xclk_handshake_chk #(.W(W)) u_chk (.*);

// File: tb/sim_xclk_handshake.sv
`timescale 1ns/1ps
module sim_xclk_handshake;
  localparam int W = 8;

  logic src_clk = 0, dst_clk = 0, src_rst = 1, dst_rst = 1, send_valid = 0;
  logic [W-1:0] send_data = '0;
  logic send_ready, rx_valid;
  logic [W-1:0] rx_data;
  realtime dst_half = 3.5;

  int checks = 0, fails = 0, accepted = 0, received = 0;
  logic [W-1:0] exp_q[$];
  bit prev_rx = 0;

  always #2 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  xclk_handshake #(.W(W)) u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge dst_clk) if (!dst_rst) begin
    if (rx_valid) begin
      chk(!prev_rx, "R4 pulse width", 2, 1);
      if (exp_q.size() == 0) chk(0, "R4 duplicate word", rx_data, -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R3/R4 word order", rx_data, e);
      end
      received++;
    end
    prev_rx = rx_valid;
  end

  task automatic send_words(int n, bit hold_valid);
    int sent = 0, low_run = 0;
    bit just = 0;
    while (sent < n) begin
      @(negedge src_clk);
      if (just) chk(!send_ready, "R2 ready drop", send_ready, 0);
      just = 0;
      if (!send_ready) low_run++;
      else if (low_run > 0) begin
        chk(low_run >= 3, "R5 ready low run", low_run, 3);
        chk(received == accepted, "R5/R6 delivered before ready", received, accepted);
        low_run = 0;
      end
      send_valid = hold_valid || ($urandom % 3 == 0);
      send_data = W'($urandom);
      if (send_valid && send_ready) begin
        exp_q.push_back(send_data);
        accepted++;
        sent++;
        just = 1;
      end
    end
    @(negedge src_clk);
    send_valid = 0;
  endtask

  initial begin
    repeat (5) @(negedge src_clk);
    chk(send_ready == 1, "R1 ready in reset", send_ready, 1);
    chk(rx_valid == 0, "R1 strobe in reset", rx_valid, 0);
    src_rst = 0;
    dst_rst = 0;
    repeat (3) @(negedge src_clk);
    chk(send_ready == 1, "R1 ready after reset", send_ready, 1);
    chk(rx_valid == 0, "R1 strobe after reset", rx_valid, 0);
    send_words(30, 1);
    dst_half = 11.0;
    send_words(20, 0);
    dst_half = 1.5;
    send_words(25, 1);
    for (int i = 0; i < 2000 && received != accepted; i++) @(negedge src_clk);
    repeat (50) @(negedge src_clk);
    chk(received == accepted, "R4 total delivered", received, accepted);
    chk(exp_q.size() == 0, "R4 nothing left", exp_q.size(), 0);
    chk(send_ready == 1, "R5 idle at end", send_ready, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", received, accepted);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule